// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A byte written through a one-cycle strobe lands in a one-character holding buffer. On the next baud tick, the byte moves into a shift register and the frame starts. Each bit of the frame lasts exactly one baud tick.

The frame layout comes from a few configuration inputs, which the block captures at the moment a frame is loaded:
- a 2-bit character-length code;
- a 3-bit parity code that includes the forced mark and forced space (stick) variants;
- a one-bit stop-length select.

A separate break control forces the line low whatever is being shifted.

The block reports two status flags:
- a buffer-empty flag, which shows when software may write the next byte;
- an idle flag, which shows that the shifter has nothing in flight.

When a byte is waiting at the end of a frame, the next frame follows with no gap between them. Baud-rate generation, bus decoding, oversampling and modem handshake sit outside this block.

Top module: `serial_tx_framer`

## Requirements
- R1: After reset `txd` is 1, `buf_empty` is 1 and `tx_idle` is 1, and `txd` stays 1 on ticks while no byte has been written.
- R2: A frame consists of, in order:
  - a start bit at 0;
  - the data bits, bit 0 first;
  - the parity bit, when enabled;
  - the stop bits at 1.

  Each bit occupies exactly one baud-tick interval, and the start bit begins on the first tick after the write.
- R3: The character-length code `char_len` sends this many data bits: 00 sends 5, 01 sends 6, 10 sends 7 and 11 sends 8. Data bits above that length are not sent.
- R4: The parity bit is controlled by `parity_mode`:
  - bit 0 = 0: no parity bit;
  - 001: odd parity;
  - 011: even parity;
  - 101: parity bit forced to 1;
  - 111: parity bit forced to 0.

  Odd and even parity are computed over the data bits that are actually sent.
- R5: `two_stop` = 0 gives one stop bit and `two_stop` = 1 gives two stop bits.
- R6: While `break_en` is 1, `txd` is 0 from the next clock on, regardless of the data or the idle state. Frame timing continues underneath the break.
- R7: `buf_empty` drops to 0 on the clock after an accepted write. It returns to 1 when the byte is moved into the shifter on a baud tick.
- R8: `tx_idle` is 0 from the tick that loads a frame until the tick that ends the last stop bit, provided no further byte is waiting. At all other times it is 1.
- R9: If a byte is waiting when the last stop bit ends, its start bit follows on that same tick with no idle bit in between.
- R10: A write while the holding buffer is full is discarded. The buffered byte is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | One-cycle byte write strobe |
| wr_data | input | 8 | Byte to transmit |
| baud_tick | input | 1 | One pulse per bit time |
| char_len | input | 2 | Character length code (00=5 .. 11=8 bits) |
| parity_mode | input | 3 | Parity code (xx0 none, 001 odd, 011 even, 101 mark, 111 space) |
| two_stop | input | 1 | 0 = one stop bit, 1 = two stop bits |
| break_en | input | 1 | Hold the line low while set |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding buffer empty |
| tx_idle | output | 1 | Shifter idle |

## Verification
The assertions assume two things about the inputs:
- reset is applied before the first meaningful cycle;
- every input carries a known level at each clock edge.

They make no assumption about configuration stability during a frame, because the settings are captured when the frame is loaded.

The stimulus stays inside these bounds:
- it drives `baud_tick` as single-cycle pulses four clocks apart;
- it changes inputs only on falling edges;
- it changes the configuration only when no frame of the previous settings is still waiting to be loaded.

Back-to-back pairs therefore always share one setting.

// File: rtl/serial_tx_framer.sv
module serial_tx_framer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       baud_tick,
  input  logic [1:0] char_len,
  input  logic [2:0] parity_mode,
  input  logic       two_stop,
  input  logic       break_en,
  output logic       txd,
  output logic       buf_empty,
  output logic       tx_idle
);

  localparam int DW = 8;
  localparam int MIN_DW = 5;
  localparam int FW = 1 + DW + 1 + 2;
  localparam int CW = $clog2(FW + 1);

  logic [DW-1:0] hold_q;
  logic          hold_full_q;
  logic          busy_q;
  logic [FW-1:0] shift_q;
  logic [CW-1:0] left_q;
  logic          txd_q;

  logic [FW-1:0] frame_d;
  logic [CW-1:0] len_d;
  logic [DW-1:0] dval;
  logic          pbit;
  int            nd;

  wire last_bit = busy_q && (left_q == CW'(1));
  wire load     = baud_tick && hold_full_q && (!busy_q || last_bit);

  always_comb begin
    nd   = MIN_DW + int'(char_len);
    dval = hold_q & DW'((32'd1 << nd) - 32'd1);
    case (parity_mode[2:1])
      2'b00:   pbit = ~(^dval);
      2'b01:   pbit = ^dval;
      2'b10:   pbit = 1'b1;
      default: pbit = 1'b0;
    endcase
    frame_d    = '1;
    frame_d[0] = 1'b0;
    for (int i = 0; i < DW; i++)
      if (i < nd) frame_d[i+1] = dval[i];
    for (int i = MIN_DW; i <= DW; i++)
      if (parity_mode[0] && i == nd) frame_d[i+1] = pbit;
    len_d = CW'(2 + nd + int'(parity_mode[0]) + int'(two_stop));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      busy_q      <= 1'b0;
      shift_q     <= '1;
      left_q      <= '0;
      txd_q       <= 1'b1;
    end else begin
      if (load)
        hold_full_q <= 1'b0;
      else if (wr_en && !hold_full_q) begin
        hold_q      <= wr_data;
        hold_full_q <= 1'b1;
      end
      if (baud_tick && busy_q) begin
        if (last_bit)
          busy_q <= 1'b0;
        else begin
          shift_q <= {1'b1, shift_q[FW-1:1]};
          left_q  <= left_q - CW'(1);
        end
      end
      if (load) begin
        busy_q  <= 1'b1;
        shift_q <= frame_d;
        left_q  <= len_d;
      end
      txd_q <= break_en ? 1'b0 : (busy_q ? shift_q[0] : 1'b1);
    end
  end

  assign txd       = txd_q;
  assign buf_empty = !hold_full_q;
  assign tx_idle   = !busy_q;

  assert_line_high_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle && !break_en) |=> txd);

  assert_shift_only_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !baud_tick) |=> $stable(shift_q) && $stable(left_q));

  assert_bit_count_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q >= CW'(1) && left_q <= CW'(FW)));

  assert_break_forces_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    break_en |=> !txd);

  assert_empty_stays_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_empty && !wr_en) |=> buf_empty);

  assert_buffer_drains_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> $past(baud_tick));

  assert_no_gap_between_frames_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && baud_tick && !buf_empty) |=> !tx_idle);

  assert_full_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !buf_empty && !baud_tick) |=> $stable(hold_q));

endmodule

// File: tb/serial_tx_framer_tb_top.sv
module serial_tx_framer_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, wr_en, baud_tick, two_stop, break_en;
  logic [7:0] wr_data;
  logic [1:0] char_len;
  logic [2:0] parity_mode;
  logic       txd, buf_empty, tx_idle;
  int         checks = 0, fails = 0;
  bit         done = 0;

  serial_tx_framer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .baud_tick(baud_tick), .char_len(char_len), .parity_mode(parity_mode),
    .two_stop(two_stop), .break_en(break_en),
    .txd(txd), .buf_empty(buf_empty), .tx_idle(tx_idle));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void exp_frame(input logic [7:0] d, input logic [1:0] l,
                                    input logic [2:0] p, input logic ts,
                                    output logic [11:0] f, output int n);
    logic par;
    f = '1; n = 0; par = 1'b0;
    f[n] = 1'b0; n++;
    for (int i = 0; i < 5 + l; i++) begin f[n] = d[i]; par ^= d[i]; n++; end
    if (p[0]) begin
      case (p[2:1])
        2'b00: f[n] = ~par;
        2'b01: f[n] = par;
        2'b10: f[n] = 1'b1;
        default: f[n] = 1'b0;
      endcase
      n++;
    end
    n += ts ? 2 : 1;
  endfunction

  task automatic bit_period(output logic b, output logic idl);
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
    repeat (3) @(negedge clk);
    b = txd; idl = tx_idle;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_frame(input logic [7:0] d, input logic [1:0] l, input logic [2:0] p,
                           input logic ts, input int nwr, input logic [7:0] w1,
                           input logic [7:0] w2, input string req);
    logic [11:0] f; int n; logic b, idl;
    char_len = l; parity_mode = p; two_stop = ts;
    exp_frame(d, l, p, ts, f, n);
    for (int i = 0; i < n; i++) begin
      bit_period(b, idl);
      chk(req, $sformatf("bit %0d of frame %02h", i, d), b, f[i]);
      chk("R8", "idle flag during frame", idl, 0);
      if (i == 0) begin
        chk("R7", "buffer empty after load", buf_empty, 1);
        if (nwr >= 1) begin
          wr(w1);
          chk("R7", "buffer full after write", buf_empty, 0);
        end
        if (nwr >= 2) wr(w2);
      end
    end
  endtask

  task automatic idle_check(input string req);
    logic b, idl;
    bit_period(b, idl);
    chk(req, "line high when idle", b, 1);
    chk("R8", "idle flag after frame", idl, 1);
    chk("R7", "buffer empty when idle", buf_empty, 1);
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] l, input logic [2:0] p,
                      input logic ts, input string req);
    wr(d);
    chk("R7", "buffer full after write", buf_empty, 0);
    chk("R8", "still idle before tick", tx_idle, 1);
    run_frame(d, l, p, ts, 0, 8'h00, 8'h00, req);
    idle_check(req);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R2 actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic b, idl;
    int unsigned seed_dummy;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; baud_tick = 1'b0;
    char_len = 2'b11; parity_mode = 3'b000; two_stop = 1'b0; break_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "txd after reset", txd, 1);
    chk("R1", "buf_empty after reset", buf_empty, 1);
    chk("R1", "tx_idle after reset", tx_idle, 1);
    bit_period(b, idl);
    chk("R1", "txd on tick with no data", b, 1);
    chk("R1", "idle on tick with no data", idl, 1);

    for (int l = 0; l < 4; l++) send(8'hA5, 2'(l), 3'b000, 1'b0, "R3");
    send(8'h3C, 2'b11, 3'b110, 1'b0, "R4");
    send(8'h3C, 2'b11, 3'b001, 1'b0, "R4");
    send(8'h3D, 2'b11, 3'b001, 1'b0, "R4");
    send(8'h3C, 2'b11, 3'b011, 1'b0, "R4");
    send(8'h3D, 2'b11, 3'b011, 1'b0, "R4");
    send(8'h00, 2'b11, 3'b101, 1'b0, "R4");
    send(8'hFF, 2'b11, 3'b111, 1'b0, "R4");
    send(8'hE1, 2'b00, 3'b001, 1'b0, "R4");
    send(8'h0F, 2'b11, 3'b000, 1'b1, "R5");
    send(8'h81, 2'b10, 3'b011, 1'b1, "R5");

    wr(8'h11);
    run_frame(8'h11, 2'b11, 3'b001, 1'b0, 1, 8'h22, 8'h00, "R9");
    run_frame(8'h22, 2'b11, 3'b001, 1'b0, 0, 8'h00, 8'h00, "R9");
    idle_check("R9");

    wr(8'h33);
    run_frame(8'h33, 2'b11, 3'b000, 1'b0, 2, 8'h44, 8'h55, "R10");
    run_frame(8'h44, 2'b11, 3'b000, 1'b0, 0, 8'h00, 8'h00, "R10");
    idle_check("R10");

    break_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6", "break while idle", txd, 0);
    char_len = 2'b11; parity_mode = 3'b000; two_stop = 1'b0;
    wr(8'hFF);
    for (int i = 0; i < 10; i++) begin
      bit_period(b, idl);
      chk("R6", "break during frame", b, 0);
    end
    break_en = 1'b0;
    idle_check("R6");

    seed_dummy = $urandom(32'd20240);
    for (int k = 0; k < 40; k++) begin
      logic [7:0] d1, d2; logic [1:0] l; logic [2:0] p; logic ts;
      d1 = 8'($urandom); d2 = 8'($urandom);
      l = 2'($urandom); p = 3'($urandom); ts = 1'($urandom);
      if ($urandom % 2 == 0) begin
        send(d1, l, p, ts, "R2");
      end else begin
        wr(d1);
        run_frame(d1, l, p, ts, 1, d2, 8'h00, "R2");
        run_frame(d2, l, p, ts, 0, 8'h00, 8'h00, "R9");
        idle_check("R2");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule